// File: doc/BRIEF.md
# DMA Snooper with Stream Gate

This block sits next to the CPU's DMA controller and the cartridge ROM path. It listens to every CPU write aimed at the eight DMA channel register blocks. For each channel it keeps a 24-bit source address and a 16-bit transfer length. The writes themselves are forwarded, unchanged, to the real DMA controller one cycle later.

Two enable vectors come from outside. A channel is armed when its bit is set in both. When a CPU read in the upper address region equals the recorded address of an armed channel, the byte is served from a streaming decompressor instead of the mapped ROM. The lowest armed channel wins.

DMA reads here use a fixed source address, so every byte of a transfer repeats the same address. The first such hit starts the decompressor with that address. Each hit pulls one byte and counts the channel's length down by one. When the length runs out, the stream closes and a one-cycle clear pulse tells the owner of the second enable vector to drop that channel's bit.

Top module: `dma_stream_gate`

## Requirements
- R1: A snooped write is decoded only when `snp_addr[15:7]` equals 9'h086 (window 0x4300 to 0x437F). Bits 6:4 select the channel and bits 3:0 the register. Registers 2, 3 and 4 load address bits 7:0, 15:8 and 23:16. Registers 5 and 6 load size bits 7:0 and 15:8. Every other register, and every address outside the window, changes nothing.
- R2: Each cycle, `dmac_we`, `dmac_addr` and `dmac_data` repeat the `snp_we`, `snp_addr` and `snp_data` values of the previous cycle.
- R3: Channel n is eligible only when `en_a[n]` and `en_b[n]` are both 1. Among eligible channels whose address matches, the lowest index wins.
- R4: A read is a hit only when `rd_addr[23:22]` is 2'b11 and `rd_addr` equals the recorded address exactly. Neighbouring addresses and lower-region reads miss.
- R5: On a hit while no stream is active, `dec_init` pulses for one cycle together with `dec_rd`, with `dec_init_addr` equal to the hit address. The stream then becomes active, and later hits do not pulse `dec_init`.
- R6: Each hit produces exactly one `dec_rd` pulse. The returned byte is `dec_byte`, taken while `dec_rd` and `dec_valid` are high. The winning channel's size drops by one.
- R7: A hit on a channel whose size is 1 ends the stream and pulses `clr_b[n]` for one cycle. A hit on size 0 wraps the size to 16'hFFFF and gives no clear.
- R8: After reset, all recorded addresses and sizes are zero, no stream is active, and every output is low.
- R9: A read that is not a hit returns `rom_data` as sampled with the request, and no decompressor strobe is issued.
- R10: Decompressor strobes and `clr_b` appear in the cycle after the request is sampled. `rd_valid` with `rd_data` appears one cycle after that, for hits and misses alike.
- R11: If a snooped size write to the hit channel lands in the same cycle as its hit, the written byte wins and that hit's decrement is dropped. The end-of-stream decision still follows the pre-hit size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_we | input | 1 | CPU write strobe on the DMA register bus |
| snp_addr | input | 16 | CPU write address |
| snp_data | input | 8 | CPU write data |
| dmac_we | output | 1 | Forwarded write strobe to the DMA controller |
| dmac_addr | output | 16 | Forwarded write address |
| dmac_data | output | 8 | Forwarded write data |
| en_a | input | 8 | First per-channel enable vector |
| en_b | input | 8 | Second per-channel enable vector, owned outside |
| clr_b | output | 8 | One-cycle request to clear a bit of `en_b` |
| rd_req | input | 1 | CPU read request |
| rd_addr | input | 24 | CPU read address |
| rom_data | input | 8 | Mapped ROM byte for `rd_addr` |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| dec_init | output | 1 | Decompressor start pulse |
| dec_init_addr | output | 24 | Start address for the decompressor |
| dec_rd | output | 1 | Decompressor byte request pulse |
| dec_valid | input | 1 | Decompressor byte valid |
| dec_byte | input | 8 | Decompressed byte |

## Verification
A single channel is programmed and drained to zero; this separates the first-hit start from later hits and shows the clear pulse. Two channels share one address under changing enable masks, which separates the both-enables rule from the lowest-index priority. Hits are interleaved back to back with misses at a neighbouring address, in the lower region and outside the snoop window; this exposes loose address compares, loose window decodes and a mismatch in read latency between the ROM path and the stream path. A size write landing on the same cycle as a hit, and a hit on a zero size, cover the collision and wrap corners.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
  localparam int NUM_CH       = 8;
  localparam int ADDR_W       = 24;
  localparam int LEN_W        = 16;
  localparam int BYTE_W       = 8;
  localparam logic [15:0] SNOOP_BASE = 16'h4300;
  localparam logic [3:0]  REG_ADDR_LO = 4'd2;
  localparam logic [3:0]  REG_LEN_LO  = 4'd5;
endpackage

// File: rtl/sgate_snoop.sv
module sgate_snoop
  import sgate_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int SW  = LEN_W,
  localparam int CW = $clog2(NCH),
  localparam int AB = AW / BYTE_W,
  localparam int SB = SW / BYTE_W,
  localparam int WLO = CW + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_we,
  input  logic [15:0]             snp_addr,
  input  logic [7:0]              snp_data,
  input  logic                    dec_en,
  input  logic [CW-1:0]           dec_ch,
  output logic [NCH-1:0][AW-1:0]  ch_addr,
  output logic [NCH-1:0][SW-1:0]  ch_size,
  output logic                    dmac_we,
  output logic [15:0]             dmac_addr,
  output logic [7:0]              dmac_data
);
  logic          win_hit;
  logic [CW-1:0] wr_ch;
  logic [3:0]    wr_reg;

  assign win_hit = snp_we && (snp_addr[15:WLO] == SNOOP_BASE[15:WLO]);
  assign wr_ch   = snp_addr[4 +: CW];
  assign wr_reg  = snp_addr[3:0];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic          sel;
    logic          len_wr;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] size_q;

    assign sel    = win_hit && (wr_ch == CW'(n));
    assign len_wr = sel && (wr_reg >= REG_LEN_LO) && (wr_reg < REG_LEN_LO + 4'(SB));

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
        size_q <= '0;
      end else begin
        for (int b = 0; b < AB; b++) begin
          if (sel && wr_reg == REG_ADDR_LO + 4'(b)) addr_q[BYTE_W*b +: BYTE_W] <= snp_data;
        end
        if (len_wr) begin
          for (int b = 0; b < SB; b++) begin
            if (wr_reg == REG_LEN_LO + 4'(b)) size_q[BYTE_W*b +: BYTE_W] <= snp_data;
          end
        end else if (dec_en && dec_ch == CW'(n)) begin
          size_q <= size_q - 1'b1;
        end
      end
    end

    assign ch_addr[n] = addr_q;
    assign ch_size[n] = size_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmac_we   <= 1'b0;
      dmac_addr <= '0;
      dmac_data <= '0;
    end else begin
      dmac_we   <= snp_we;
      dmac_addr <= snp_addr;
      dmac_data <= snp_data;
    end
  end
endmodule

// File: rtl/sgate_match.sv
module sgate_match
  import sgate_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int SW  = LEN_W,
  localparam int CW = $clog2(NCH)
) (
  input  logic                    rd_req,
  input  logic [AW-1:0]           rd_addr,
  input  logic [NCH-1:0]          en_a,
  input  logic [NCH-1:0]          en_b,
  input  logic [NCH-1:0][AW-1:0]  ch_addr,
  input  logic [NCH-1:0][SW-1:0]  ch_size,
  output logic                    hit,
  output logic [CW-1:0]           hit_ch,
  output logic [SW-1:0]           hit_size
);
  logic [NCH-1:0] elig;
  logic           upper;

  for (genvar n = 0; n < NCH; n++) begin : g_cmp
    assign elig[n] = en_a[n] && en_b[n] && (ch_addr[n] == rd_addr);
  end

  assign upper = (rd_addr[AW-1:AW-2] == 2'b11);

  always_comb begin
    hit_ch = '0;
    for (int n = NCH - 1; n >= 0; n--) begin
      if (elig[n]) hit_ch = CW'(n);
    end
  end

  assign hit      = rd_req && upper && (|elig);
  assign hit_size = ch_size[hit_ch];
endmodule

// File: rtl/sgate_stream.sv
module sgate_stream
  import sgate_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int SW  = LEN_W,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      rom_data,
  input  logic            hit,
  input  logic [CW-1:0]   hit_ch,
  input  logic [SW-1:0]   hit_size,
  input  logic            dec_valid,
  input  logic [7:0]      dec_byte,
  output logic            dec_init,
  output logic [AW-1:0]   dec_init_addr,
  output logic            dec_rd,
  output logic [NCH-1:0]  clr_b,
  output logic            rd_valid,
  output logic [7:0]      rd_data,
  output logic            active
);
  logic       s1_valid;
  logic       s1_hit;
  logic [7:0] s1_rom;
  logic       last;

  assign last = hit && (hit_size == SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active        <= 1'b0;
      s1_valid      <= 1'b0;
      s1_hit        <= 1'b0;
      s1_rom        <= '0;
      dec_init      <= 1'b0;
      dec_init_addr <= '0;
      dec_rd        <= 1'b0;
      clr_b         <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
    end else begin
      s1_valid <= rd_req;
      s1_hit   <= hit;
      s1_rom   <= rom_data;
      dec_rd   <= hit;
      dec_init <= hit && !active;
      if (hit && !active) dec_init_addr <= rd_addr;
      clr_b    <= last ? (NCH'(1) << hit_ch) : '0;
      if (hit) active <= !last;
      rd_valid <= s1_valid;
      rd_data  <= (s1_hit && dec_valid) ? dec_byte : s1_rom;
    end
  end
endmodule

// File: rtl/dma_stream_gate.sv
module dma_stream_gate
  import sgate_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int AW  = ADDR_W,
  parameter int SW  = LEN_W,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            snp_we,
  input  logic [15:0]     snp_addr,
  input  logic [7:0]      snp_data,
  output logic            dmac_we,
  output logic [15:0]     dmac_addr,
  output logic [7:0]      dmac_data,
  input  logic [NCH-1:0]  en_a,
  input  logic [NCH-1:0]  en_b,
  output logic [NCH-1:0]  clr_b,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      rom_data,
  output logic            rd_valid,
  output logic [7:0]      rd_data,
  output logic            dec_init,
  output logic [AW-1:0]   dec_init_addr,
  output logic            dec_rd,
  input  logic            dec_valid,
  input  logic [7:0]      dec_byte
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][SW-1:0] ch_size;
  logic                   hit;
  logic [CW-1:0]          hit_ch;
  logic [SW-1:0]          hit_size;
  logic                   strm_active;

  sgate_snoop #(.NCH(NCH), .AW(AW), .SW(SW)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
    .dec_en(hit), .dec_ch(hit_ch),
    .ch_addr(ch_addr), .ch_size(ch_size),
    .dmac_we(dmac_we), .dmac_addr(dmac_addr), .dmac_data(dmac_data)
  );

  sgate_match #(.NCH(NCH), .AW(AW), .SW(SW)) u_match (
    .rd_req(rd_req), .rd_addr(rd_addr), .en_a(en_a), .en_b(en_b),
    .ch_addr(ch_addr), .ch_size(ch_size),
    .hit(hit), .hit_ch(hit_ch), .hit_size(hit_size)
  );

  sgate_stream #(.NCH(NCH), .AW(AW), .SW(SW)) u_stream (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(rd_addr), .rom_data(rom_data),
    .hit(hit), .hit_ch(hit_ch), .hit_size(hit_size),
    .dec_valid(dec_valid), .dec_byte(dec_byte),
    .dec_init(dec_init), .dec_init_addr(dec_init_addr), .dec_rd(dec_rd),
    .clr_b(clr_b), .rd_valid(rd_valid), .rd_data(rd_data),
    .active(strm_active)
  );
endmodule

// File: rtl/sgate_checks.sv
module sgate_checks #(
  parameter int NCH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            snp_we,
  input logic [15:0]     snp_addr,
  input logic [7:0]      snp_data,
  input logic            dmac_we,
  input logic [15:0]     dmac_addr,
  input logic [7:0]      dmac_data,
  input logic            rd_req,
  input logic            rd_valid,
  input logic            dec_init,
  input logic            dec_rd,
  input logic [NCH-1:0]  clr_b,
  input logic            strm_active
);
  // R2: forwarded write follows one cycle later
  p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
    snp_we |=> dmac_we && dmac_addr == $past(snp_addr) && dmac_data == $past(snp_data));

  // R10: every request gets its result two cycles later
  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 rd_valid);

  // R9: no decompressor strobe without a read
  p_strobe_needs_read_r9: assert property (@(posedge clk) disable iff (rst)
    dec_rd |-> $past(rd_req));

  // R5: start pulse always travels with a byte request
  p_init_with_read_r5: assert property (@(posedge clk) disable iff (rst)
    dec_init |-> dec_rd);

  // R5: start only from an idle stream
  p_init_only_idle_r5: assert property (@(posedge clk) disable iff (rst)
    dec_init |-> !$past(strm_active));

  // R7: at most one channel cleared, and only at the close of a stream
  p_clear_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_b));

  p_clear_closes_r7: assert property (@(posedge clk) disable iff (rst)
    (|clr_b) |-> dec_rd && !strm_active);

  // R6: each byte request yields a result next cycle
  p_byte_delivered_r6: assert property (@(posedge clk) disable iff (rst)
    dec_rd |=> rd_valid);
endmodule

bind dma_stream_gate sgate_checks #(.NCH(NCH)) u_checks (
  .clk(clk), .rst(rst), .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
  .dmac_we(dmac_we), .dmac_addr(dmac_addr), .dmac_data(dmac_data),
  .rd_req(rd_req), .rd_valid(rd_valid), .dec_init(dec_init), .dec_rd(dec_rd),
  .clr_b(clr_b), .strm_active(strm_active)
);

// File: tb/dma_stream_gate_bench.sv
module dma_stream_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int AW  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic            snp_we = 1'b0;
  logic [15:0]     snp_addr = '0;
  logic [7:0]      snp_data = '0;
  logic            dmac_we;
  logic [15:0]     dmac_addr;
  logic [7:0]      dmac_data;
  logic [NCH-1:0]  en_a = '0;
  logic [NCH-1:0]  en_b = '0;
  logic [NCH-1:0]  clr_b;
  logic            rd_req = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [7:0]      rom_data;
  logic            rd_valid;
  logic [7:0]      rd_data;
  logic            dec_init;
  logic [AW-1:0]   dec_init_addr;
  logic            dec_rd;
  logic            dec_valid;
  logic [7:0]      dec_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_stream_gate u_dma_stream_gate (
    .clk(clk), .rst(rst), .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
    .dmac_we(dmac_we), .dmac_addr(dmac_addr), .dmac_data(dmac_data),
    .en_a(en_a), .en_b(en_b), .clr_b(clr_b),
    .rd_req(rd_req), .rd_addr(rd_addr), .rom_data(rom_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dec_init(dec_init), .dec_init_addr(dec_init_addr), .dec_rd(dec_rd),
    .dec_valid(dec_valid), .dec_byte(dec_byte)
  );

  function automatic logic [7:0] stubf(logic [23:0] s, int i);
    return s[7:0] ^ s[15:8] ^ s[23:16] ^ 8'(i * 37 + 5);
  endfunction

  function automatic logic [7:0] romf(logic [23:0] a);
    return a[7:0] ^ a[23:16] ^ 8'h5A;
  endfunction

  // decompressor stub
  logic [23:0] st_seed;
  int          st_idx;
  always_ff @(posedge clk) begin
    if (rst) begin
      st_seed <= '0;
      st_idx  <= 0;
    end else if (dec_init) begin
      st_seed <= dec_init_addr;
      st_idx  <= 1;
    end else if (dec_rd) begin
      st_idx  <= st_idx + 1;
    end
  end
  assign dec_valid = dec_rd;
  assign dec_byte  = dec_init ? stubf(dec_init_addr, 0) : stubf(st_seed, st_idx);
  assign rom_data  = romf(rd_addr);

  // reference model state
  logic [23:0] m_addr [NCH];
  logic [15:0] m_size [NCH];
  bit          m_active;
  logic [23:0] m_seed;
  int          m_idx;

  // expected results of the previous request (rd path)
  bit          q_v;
  bit          q_hit;
  logic [7:0]  q_d;

  int checks = 0;
  int errors = 0;
  string tag = "R8 reset";
  int hits_seen = 0;
  int inits_seen = 0;
  logic [7:0] clr_seen = '0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit          hit = 0;
    int          hn = 0;
    bit          e_init = 0;
    logic [23:0] e_iaddr = '0;
    logic [7:0]  e_clr = '0;
    logic [7:0]  e_byte = '0;
    bit          sel;
    int          c;
    int          r;
    bit          e_dwe = snp_we;
    logic [15:0] e_daddr = snp_addr;
    logic [7:0]  e_ddata = snp_data;
    bit          n_v = rd_req;
    logic [7:0]  n_d;
    if (rd_req && rd_addr[23:22] == 2'b11) begin
      for (int n = 0; n < NCH; n++) begin
        if (!hit && en_a[n] && en_b[n] && m_addr[n] == rd_addr) begin
          hit = 1; hn = n;
        end
      end
    end
    if (hit) begin
      if (!m_active) begin
        e_init = 1; e_iaddr = rd_addr; m_seed = rd_addr; m_idx = 0; m_active = 1;
      end
      e_byte = stubf(m_seed, m_idx);
      m_idx++;
      if (m_size[hn] == 16'd1) begin
        e_clr = 8'(1 << hn); m_active = 0;
      end
    end
    n_d = hit ? e_byte : romf(rd_addr);
    sel = snp_we && snp_addr[15:7] == 9'h086;
    c = int'(snp_addr[6:4]);
    r = int'(snp_addr[3:0]);
    if (hit && !(sel && c == hn && (r == 5 || r == 6))) m_size[hn] = m_size[hn] - 16'd1;
    if (sel) begin
      case (r)
        2: m_addr[c][7:0]   = snp_data;
        3: m_addr[c][15:8]  = snp_data;
        4: m_addr[c][23:16] = snp_data;
        5: m_size[c][7:0]   = snp_data;
        6: m_size[c][15:8]  = snp_data;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk("R5", "dec_init", 32'(dec_init), 32'(e_init));
    if (e_init) chk("R5", "dec_init_addr", 32'(dec_init_addr), 32'(e_iaddr));
    chk("R6", "dec_rd", 32'(dec_rd), 32'(hit));
    chk("R7", "clr_b", 32'(clr_b), 32'(e_clr));
    chk("R2", "dmac_we", 32'(dmac_we), 32'(e_dwe));
    if (e_dwe) chk("R2", "dmac addr/data", {dmac_addr, dmac_data}, {e_daddr, e_ddata});
    chk("R10", "rd_valid", 32'(rd_valid), 32'(q_v));
    if (q_v) chk(q_hit ? "R6" : "R9", "rd_data", 32'(rd_data), 32'(q_d));
    q_v = n_v; q_hit = hit; q_d = n_d;
    if (dec_rd) hits_seen++;
    if (dec_init) inits_seen++;
    clr_seen |= clr_b;
    en_b &= ~clr_b;
    snp_we = 0;
    rd_req = 0;
  endtask

  task automatic snoop(logic [15:0] a, logic [7:0] d);
    snp_we = 1; snp_addr = a; snp_data = d;
    tick();
  endtask

  task automatic prog(int ch, logic [23:0] a, logic [15:0] s);
    logic [15:0] base = 16'h4300 | 16'(ch << 4);
    snoop(base | 16'd2, a[7:0]);
    snoop(base | 16'd3, a[15:8]);
    snoop(base | 16'd4, a[23:16]);
    snoop(base | 16'd5, s[7:0]);
    snoop(base | 16'd6, s[15:8]);
  endtask

  task automatic rd(logic [23:0] a);
    rd_req = 1; rd_addr = a;
    tick();
  endtask

  task automatic clear_stats();
    hits_seen = 0; inits_seen = 0; clr_seen = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < NCH; n++) begin m_addr[n] = '0; m_size[n] = '0; end
    m_active = 0; m_seed = '0; m_idx = 0;
    q_v = 0; q_hit = 0; q_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R8: quiet outputs after reset
    chk("R8", "outputs after reset", {dec_init, dec_rd, rd_valid, dmac_we, clr_b}, '0);
    en_a = 8'hFF; en_b = 8'hFF;
    rd(24'hC00000);
    tick(); tick();
    chk("R8", "zero table gives no hit", 32'(hits_seen), 32'd0);

    // R1: decode and ignored registers
    tag = "R1 decode"; clear_stats();
    en_a = 8'h00; en_b = 8'h00;
    prog(3, 24'hC12345, 16'd3);
    snoop(16'h4330, 8'hFF);
    snoop(16'h4331, 8'hFF);
    snoop(16'h4337, 8'hFF);
    snoop(16'h43A2, 8'h99);
    snoop(16'h4B32, 8'h77);
    tag = "R1/R5/R7 drain ch3";
    en_a = 8'h08; en_b = 8'h08;
    rd(24'hC12345); rd(24'hC12345); rd(24'hC12345);
    tick(); tick();
    chk("R5", "one start per stream", 32'(inits_seen), 32'd1);
    chk("R6", "bytes delivered", 32'(hits_seen), 32'd3);
    chk("R7", "channel 3 cleared", 32'(clr_seen), 32'h08);
    chk("R7", "en_b bit dropped", 32'(en_b), 32'h00);
    tag = "R9 after drain"; clear_stats();
    rd(24'hC12345); tick(); tick();
    chk("R9", "disarmed channel misses", 32'(hits_seen), 32'd0);

    // R3: both enables and priority
    tag = "R3 priority"; clear_stats();
    en_a = 8'h00; en_b = 8'h00;
    prog(1, 24'hD00010, 16'd2);
    prog(5, 24'hD00010, 16'd2);
    en_a = 8'h20; en_b = 8'h22;
    rd(24'hD00010); rd(24'hD00010); tick(); tick();
    chk("R3", "only ch5 eligible", 32'(clr_seen), 32'h20);
    clear_stats();
    prog(5, 24'hD00010, 16'd2);
    en_a = 8'h22; en_b = 8'h22;
    rd(24'hD00010); rd(24'hD00010); tick(); tick();
    chk("R3", "lowest channel wins", 32'(clr_seen), 32'h02);
    chk("R3", "ch5 still armed", 32'(en_b), 32'h20);

    // R4: exact compare and upper region, back to back
    tag = "R4 compare"; clear_stats();
    en_a = 8'h00; en_b = 8'h00;
    prog(6, 24'h500010, 16'd4);
    prog(0, 24'hE00020, 16'd4);
    en_a = 8'h41; en_b = 8'h41;
    rd(24'h500010); rd(24'hE00021); rd(24'hE00020);
    rd(24'h123456); rd(24'hE00020); rd(24'hE00020);
    tick(); tick();
    chk("R4", "hits only on exact upper address", 32'(hits_seen), 32'd3);
    chk("R4", "no clear before end", 32'(clr_seen), 32'h00);

    // R11: size write collides with a hit
    tag = "R11 collision"; clear_stats();
    en_a = 8'h00; en_b = 8'h00;
    prog(7, 24'hF0FFFF, 16'd5);
    en_a = 8'h80; en_b = 8'h80;
    rd_req = 1; rd_addr = 24'hF0FFFF;
    snoop(16'h4375, 8'h02);
    rd(24'hF0FFFF);
    chk("R11", "no clear after second hit", 32'(clr_seen), 32'h00);
    rd(24'hF0FFFF); tick(); tick();
    chk("R11", "written size wins", 32'(clr_seen), 32'h80);
    chk("R11", "hits", 32'(hits_seen), 32'd3);

    // R7: zero size wraps
    tag = "R7 wrap"; clear_stats();
    en_a = 8'h00; en_b = 8'h00;
    prog(2, 24'hC00002, 16'd0);
    en_a = 8'h04; en_b = 8'h04;
    rd(24'hC00002); rd(24'hC00002); tick(); tick();
    chk("R7", "zero size gives no clear", 32'(clr_seen), 32'h00);
    chk("R7", "start only once", 32'(inits_seen), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule